// File: doc/BRIEF.md
# Pluggable Module Management Interrupt Controller

This block is the management-plane control logic inside a pluggable optical transceiver. It filters the host's active-low reset pin so that short glitches are ignored and only a sufficiently long low level resets the module. It runs an initialization interval after power-up and after each such reset. While that interval lasts, a data-not-ready status bit stays set. When the interval ends, the block clears that bit and raises an interrupt to report that it is ready.

Once running, the block watches the monitor conditions: per-lane receive loss of signal, per-lane transmit fault, and a set of generic alarms. A rising edge on any of them sets a latched flag. The active-low interrupt output is pulled low while any latched flag is set and not masked. Flags clear only when the host reads the byte that holds them. Masks stop a flag from reaching the interrupt pin, but the flag itself still latches.

Host access is a byte-wide register read/write port, taken to be the decoded output of a two-wire serial slave. That port is honoured only while the active-low module-select input is held low. The reset, select and monitor inputs all pass through two-stage synchronizers. The reset pulse threshold and the initialization interval are derived from a clock-frequency parameter.

Top module: `mgmt_irq_ctrl`

## Requirements
- R1: After the power-on reset `por_n` is released, status byte at address 2 bit 0 (data-not-ready) reads 1 for the whole initialization interval of INIT_MS × CLK_KHZ cycles. It reads 0 after that interval.
- R2: At the end of every initialization, a ready flag at address 5 bit 0 is set and `intl_n` goes low. No reset pulse is needed for this after power-on. Reading address 5 returns that flag and clears it.
- R3: A low level on `resetl_pin` lasting fewer than RST_MIN_US × CLK_KHZ / 1000 clock cycles has no effect on status, flags or masks.
- R4: A low level lasting at least that many cycles resets the module. Data-not-ready is set, all flags and masks are cleared, and this state is held while the pin stays low. The initialization interval starts only when the pin returns high.
- R5: While running, a rising edge of `los_raw[i]` sets address 3 bit i, and a rising edge of `txfault_raw[i]` sets address 3 bit 4+i. A rising edge of `alarm_raw[j]` sets address 4 bit j. A condition already high when initialization ends counts as a rising edge. Falling edges set nothing.
- R6: Reading address 3 or 4 returns the flags of that byte and clears them. `intl_n` returns high once no unmasked flag remains, and stays low while another unmasked flag is still set.
- R7: A flag whose rising edge arrives in the same cycle as a clearing read of its byte stays set.
- R8: Mask bytes at addresses 6 (for address 3) and 7 (for address 4) are readable and writable and reset to 0. A bit value of 1 masks its flag. A masked flag still latches and reads back, but it does not pull `intl_n` low. Clearing the mask while the flag is still set pulls `intl_n` low.
- R9: `intl_n` is low exactly when the ready flag or any unmasked latched flag is set. The output lags the flag by one register.
- R10: While `modsel_n` is high, reads return 0 and clear nothing, and writes change nothing.
- R11: Writes to addresses 2 to 5 and to unmapped addresses are ignored. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| resetl_pin | input | 1 | Host module-reset pin, active low, asynchronous |
| modsel_n | input | 1 | Module select, active low, asynchronous |
| los_raw | input | 4 | Per-lane receive loss-of-signal conditions |
| txfault_raw | input | 4 | Per-lane transmit fault conditions |
| alarm_raw | input | NALM | Generic alarm conditions |
| reg_re | input | 1 | Register read strobe, one cycle per byte |
| reg_we | input | 1 | Register write strobe, one cycle per byte |
| reg_addr | input | 7 | Byte address in the 128-byte lower space |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_re` is high |
| intl_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with CLK_KHZ=1000, RST_MIN_US=4, INIT_MS=1 and NALM=3. With these values the reset threshold is four cycles and the initialization interval is 1000 cycles. That brings both sides of the pulse threshold, and both ends of the initialization window, within a short run. All eleven flag positions are swept one at a time: set, read and cleared, then masked, latched and unmasked. The same-cycle set/clear race is placed on an exact cycle, counted through the synchronizer stages.

// File: rtl/mgmt_irq_ctrl.sv
module mgmt_irq_ctrl #(
  parameter int CLK_KHZ    = 100000,
  parameter int RST_MIN_US = 2,
  parameter int INIT_MS    = 2000,
  parameter int NALM       = 8
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            resetl_pin,
  input  logic            modsel_n,
  input  logic [3:0]      los_raw,
  input  logic [3:0]      txfault_raw,
  input  logic [NALM-1:0] alarm_raw,
  input  logic            reg_re,
  input  logic            reg_we,
  input  logic [6:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            intl_n
);
  localparam int RST_RAW  = CLK_KHZ * RST_MIN_US / 1000;
  localparam int RST_CYC  = (RST_RAW < 2) ? 2 : RST_RAW;
  localparam int INIT_RAW = CLK_KHZ * INIT_MS;
  localparam int INIT_CYC = (INIT_RAW < 1) ? 1 : INIT_RAW;
  localparam int RW       = $clog2(RST_CYC + 1);
  localparam int IW       = $clog2(INIT_CYC + 1);
  localparam int NM       = 8 + NALM;

  localparam logic [6:0] A_STAT = 7'd2;
  localparam logic [6:0] A_FLG0 = 7'd3;
  localparam logic [6:0] A_FLG1 = 7'd4;
  localparam logic [6:0] A_RDY  = 7'd5;
  localparam logic [6:0] A_MSK0 = 7'd6;
  localparam logic [6:0] A_MSK1 = 7'd7;

  typedef enum logic [1:0] {S_INIT = 2'd0, S_HOLD = 2'd1, S_RUN = 2'd2} st_t;

  logic [1:0]    rs_q, ms_q;
  logic [NM-1:0] m1, m2, mprev, flg, mask;
  logic [RW-1:0] lowcnt;
  logic [IW-1:0] icnt;
  st_t           st;
  logic          rdyf, irq_q;

  wire rs_hi   = rs_q[1];
  wire sel     = ~ms_q[1];
  wire running = (st == S_RUN);
  wire dnr     = ~running;
  wire take    = ~rs_hi && (lowcnt == RW'(RST_CYC - 1));
  wire done    = (st == S_INIT) && (icnt == IW'(INIT_CYC - 1)) && !take;
  wire rd_ok   = reg_re && sel;
  wire wr_ok   = reg_we && sel;
  wire [NM-1:0] rise = m2 & ~mprev;

  logic [NM-1:0] clr;
  always_comb begin
    clr = '0;
    if (rd_ok && reg_addr == A_FLG0) clr[7:0] = '1;
    if (rd_ok && reg_addr == A_FLG1) clr[NM-1:8] = '1;
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rs_q <= 2'b11;
      ms_q <= 2'b11;
      m1 <= '0;
      m2 <= '0;
    end else begin
      rs_q <= {rs_q[0], resetl_pin};
      ms_q <= {ms_q[0], modsel_n};
      m1 <= {alarm_raw, txfault_raw, los_raw};
      m2 <= m1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) lowcnt <= '0;
    else if (rs_hi) lowcnt <= '0;
    else if (lowcnt != RW'(RST_CYC - 1)) lowcnt <= lowcnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st <= S_INIT;
      icnt <= '0;
    end else if (take) begin
      st <= S_HOLD;
      icnt <= '0;
    end else begin
      case (st)
        S_HOLD: if (rs_hi) st <= S_INIT;
        S_INIT: if (done) st <= S_RUN; else icnt <= icnt + 1'b1;
        default: st <= S_RUN;
      endcase
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      mprev <= '0;
      flg <= '0;
      rdyf <= 1'b0;
      mask <= '0;
      irq_q <= 1'b0;
    end else begin
      mprev <= running ? m2 : '0;
      if (take || !running) flg <= '0;
      else flg <= (flg & ~clr) | rise;
      if (take) rdyf <= 1'b0;
      else if (done) rdyf <= 1'b1;
      else if (rd_ok && reg_addr == A_RDY) rdyf <= 1'b0;
      if (take) mask <= '0;
      else if (wr_ok && reg_addr == A_MSK0) mask[7:0] <= reg_wdata;
      else if (wr_ok && reg_addr == A_MSK1) mask[NM-1:8] <= reg_wdata[NALM-1:0];
      irq_q <= rdyf || (|(flg & ~mask));
    end

  assign intl_n = ~irq_q;

  logic [7:0] alf, alm;
  always_comb begin
    alf = '0;
    alm = '0;
    alf[NALM-1:0] = flg[NM-1:8];
    alm[NALM-1:0] = mask[NM-1:8];
    reg_rdata = '0;
    if (rd_ok)
      case (reg_addr)
        A_STAT:  reg_rdata = {7'd0, dnr};
        A_FLG0:  reg_rdata = flg[7:0];
        A_FLG1:  reg_rdata = alf;
        A_RDY:   reg_rdata = {7'd0, rdyf};
        A_MSK0:  reg_rdata = mask[7:0];
        A_MSK1:  reg_rdata = alm;
        default: reg_rdata = '0;
      endcase
  end
endmodule

module mgmt_irq_ctrl_chk #(parameter int NM = 16) (
  input logic          clk,
  input logic          por_n,
  input logic [1:0]    st,
  input logic          dnr,
  input logic          rdyf,
  input logic          take,
  input logic          rs_hi,
  input logic          sel,
  input logic          reg_re,
  input logic [6:0]    reg_addr,
  input logic [NM-1:0] flg,
  input logic [NM-1:0] mask,
  input logic          intl_n
);
  // R2
  ready_posted_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(dnr) |-> rdyf);
  // R3
  short_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == 2'd2 && rs_hi) |=> (st != 2'd1));
  // R4
  hold_wipe_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == 2'd1) |-> (dnr && flg == '0 && mask == '0 && !rdyf));
  // R5
  flag_when_run_chk: assert property (@(posedge clk) disable iff (!por_n)
    (|flg) |-> !dnr);
  // R9
  idle_pin_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!rdyf && (flg & ~mask) == '0) |=> intl_n);
  // R10
  desel_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!sel && rs_hi) |=> $stable(mask));
  // R2
  ready_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rdyf) |-> $past(take || (reg_re && sel && reg_addr == 7'd5)));
endmodule

bind mgmt_irq_ctrl mgmt_irq_ctrl_chk #(.NM(NM)) u_chk (
  .clk(clk), .por_n(por_n), .st(st), .dnr(dnr), .rdyf(rdyf), .take(take),
  .rs_hi(rs_hi), .sel(sel), .reg_re(reg_re), .reg_addr(reg_addr),
  .flg(flg), .mask(mask), .intl_n(intl_n)
);

// File: tb/test_mgmt_irq_ctrl.sv
module test_mgmt_irq_ctrl;
  localparam int CLK_KHZ = 1000, RST_MIN_US = 4, INIT_MS = 1, NALM = 3;
  localparam int RST_CYC = 4, INIT_CYC = 1000, NM = 8 + NALM;

  logic clk = 0, por_n = 0, resetl_pin = 1, modsel_n = 0;
  logic reg_re = 0, reg_we = 0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, d;
  logic intl_n;
  logic [NM-1:0] mon = '0;
  int total = 0, bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  mgmt_irq_ctrl #(.CLK_KHZ(CLK_KHZ), .RST_MIN_US(RST_MIN_US), .INIT_MS(INIT_MS), .NALM(NALM)) i_mgmt_irq_ctrl (
    .clk(clk), .por_n(por_n), .resetl_pin(resetl_pin), .modsel_n(modsel_n),
    .los_raw(mon[3:0]), .txfault_raw(mon[7:4]), .alarm_raw(mon[NM-1:8]),
    .reg_re(reg_re), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .intl_n(intl_n));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] v);
    reg_re = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] v);
    reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    por_n = 1;
    idle(5);
    rd(2, d); chk("R1 dnr after power-on", d, 1);
    chk("R1 intl idle during init", intl_n, 1);
    idle(INIT_CYC - 20);
    rd(2, d); chk("R1 dnr late in init", d, 1);
    idle(30);
    chk("R2 intl on ready", intl_n, 0);
    rd(2, d); chk("R1 dnr cleared", d, 0);
    rd(5, d); chk("R2 ready flag", d, 1);
    idle(3);
    chk("R6 intl released", intl_n, 1);
    rd(5, d); chk("R2 ready cleared by read", d, 0);

    for (int b = 0; b < NM; b++) begin
      logic [6:0] fa;
      fa = (b < 8) ? 7'd3 : 7'd4;
      mon[b] = 1; idle(6);
      chk("R9 intl on flag", intl_n, 0);
      rd(fa, d); chk("R5 flag bit", d, 1 << (b % 8));
      idle(3);
      chk("R6 intl after clear", intl_n, 1);
      mon[b] = 0; idle(6);
      rd(fa, d); chk("R5 falling edge sets nothing", d, 0);
    end

    for (int b = 0; b < NM; b++) begin
      logic [6:0] fa, ma;
      fa = (b < 8) ? 7'd3 : 7'd4;
      ma = (b < 8) ? 7'd6 : 7'd7;
      wr(ma, 8'(1 << (b % 8)));
      rd(ma, d); chk("R8 mask readback", d, 1 << (b % 8));
      mon[b] = 1; idle(6);
      chk("R8 masked intl idle", intl_n, 1);
      rd(fa, d); chk("R8 masked flag latched", d, 1 << (b % 8));
      mon[b] = 0; idle(6);
      wr(ma, 8'h00);
    end

    wr(6, 8'h01);
    mon[0] = 1; idle(6);
    chk("R8 masked", intl_n, 1);
    wr(6, 8'h00); idle(3);
    chk("R8 unmask resumes", intl_n, 0);
    rd(3, d); chk("R8 flag kept", d, 8'h01);
    mon[0] = 0; idle(6);

    mon[1] = 1; mon[5] = 1; mon[8] = 1; idle(6);
    rd(3, d); chk("R5 two flags", d, 8'h22);
    idle(3);
    chk("R6 intl held by other byte", intl_n, 0);
    rd(4, d); chk("R5 alarm flag", d, 8'h01);
    idle(3);
    chk("R6 intl released", intl_n, 1);
    mon = '0; idle(6);

    mon[3] = 1;
    idle(2);
    rd(3, d); chk("R7 read before set", d, 0);
    rd(3, d); chk("R7 flag survives race", d, 8'h08);
    mon[3] = 0; idle(6);

    mon[2] = 1; idle(6);
    modsel_n = 1; idle(3);
    rd(3, d); chk("R10 deselected read", d, 0);
    wr(6, 8'hFF); idle(3);
    chk("R10 intl unchanged", intl_n, 0);
    modsel_n = 0; idle(3);
    rd(6, d); chk("R10 mask untouched", d, 0);
    rd(3, d); chk("R10 flag not cleared", d, 8'h04);
    mon[2] = 0; idle(6);

    wr(3, 8'hFF); wr(2, 8'hFF); wr(5, 8'h01); wr(7'h40, 8'h55);
    idle(3);
    chk("R11 intl idle", intl_n, 1);
    rd(3, d); chk("R11 flag byte", d, 0);
    rd(2, d); chk("R11 status byte", d, 0);
    rd(7'h40, d); chk("R11 unmapped", d, 0);
    rd(7'h7F, d); chk("R11 unmapped top", d, 0);

    wr(7, 8'h05);
    resetl_pin = 0; idle(RST_CYC - 1); resetl_pin = 1;
    idle(6);
    rd(2, d); chk("R3 short pulse status", d, 0);
    rd(7, d); chk("R3 short pulse mask", d, 8'h05);

    mon[0] = 1; idle(6);
    resetl_pin = 0; idle(RST_CYC); resetl_pin = 1;
    idle(4);
    rd(2, d); chk("R4 dnr after reset", d, 1);
    rd(7, d); chk("R4 mask default", d, 0);
    chk("R4 flags wiped", intl_n, 1);
    idle(INIT_CYC + 10);
    rd(2, d); chk("R4 dnr cleared", d, 0);
    chk("R2 intl after reset", intl_n, 0);
    rd(5, d); chk("R2 ready after reset", d, 1);
    rd(3, d); chk("R5 level at init end", d, 8'h01);
    mon[0] = 0; idle(6);
    chk("R6 intl idle", intl_n, 1);

    resetl_pin = 0; idle(INIT_CYC + 50);
    rd(2, d); chk("R4 held while low", d, 1);
    resetl_pin = 1; idle(INIT_CYC - 10);
    rd(2, d); chk("R4 init from release", d, 1);
    idle(30);
    rd(2, d); chk("R4 ready after release", d, 0);
    rd(5, d); chk("R2 ready flag again", d, 1);

    finish_run();
  end
endmodule